// File: doc/BRIEF.md
# Carry-Segmented Pipelined Phase Accumulator

This block is the phase register of a numerically controlled oscillator. Every clock it adds a 32-bit increment word to a running phase. The phase wraps modulo 2^32. The top phase bit serves as a square-wave output whose frequency is set by the increment.

To shorten the critical path, the adder is split into narrow segments of `SEG_W` bits. The default is 8 bits, which gives four segments. Each segment captures its carry out in a flip-flop, and that flip-flop feeds the carry in of the segment above. As a result, a segment handles a given accumulation step one clock after the segment below it. Two sets of registers line the segments up:
- A skew line delays each segment's slice of the increment, so every segment adds the same increment word.
- A deskew line delays the lower segments' sums, so all slices of the phase output belong to the same step.

A flag goes high once the phase output first contains an increment sampled after reset. The integrating logic can leave `inc_in` changing every cycle; the result is exact regardless.

Top module: `nco_phase_acc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears itself synchronously. After that edge, `phase_out` is 0, `square_out` is 0 and `phase_valid` is 0.
- R2: An increment word sampled at a rising edge first appears in `phase_out` after NSEG more rising edges, where NSEG = 32 / `SEG_W` (4 by default). With a held increment V, `phase_out` then grows by V per cycle, modulo 2^32.
- R3: An increment that changes on every cycle is still summed exactly. Each sampled word is added exactly once, so `phase_out` always equals the modulo-2^32 sum of all words sampled up to NSEG edges earlier.
- R4: `square_out` equals bit 31 of `phase_out` in every cycle.
- R5: `phase_valid` stays low for the first NSEG rising edges after reset is released. It goes high after edge NSEG+1 and stays high until the next reset.
- R6: Carries cross every segment boundary, and the sum wraps modulo 2^32. Increment 0xFFFFFFFF therefore acts as -1. Whenever the phase wraps past 2^32, the new `phase_out` is below the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_in | input | 32 | Phase increment, sampled every rising edge |
| phase_out | output | 32 | Aligned accumulated phase |
| square_out | output | 1 | Most significant phase bit |
| phase_valid | output | 1 | High once the pipeline carries post-reset data |

## Verification
The bench attacks four corner cases:
- **Carry ripple across boundaries.** Increments such as 0x00FFFFFF and 0xFFFFFFFF force carries over every segment boundary. A carry lost or taken from the wrong step shows up as a phase that is wrong by a multiple of 256.
- **Per-cycle random increments.** These expose a skew line of the wrong depth: a segment would add an increment slice from a neighbouring step, which a held increment would hide.
- **Misaligned output slices.** A deskew line that is off by one mixes slices from adjacent steps, so the phase word is wrong during every ramp.
- **Valid timing.** A reset in mid-run, followed by a count of the edges up to `phase_valid`, catches a flag that rises one cycle early or late.

// File: rtl/nco_pkg.sv
// Package: shared helpers for the segmented phase accumulator.
// Assumes the segment width divides the phase width evenly.
package nco_pkg;

    // Number of adder segments for a phase width and segment width.
    function automatic int seg_count(input int phase_w, input int seg_w);
        return phase_w / seg_w;
    endfunction

    // Edges from reset release until the output holds post-reset data.
    function automatic int fill_edges(input int phase_w, input int seg_w);
        return seg_count(phase_w, seg_w) + 1;
    endfunction

endpackage

// File: rtl/nco_delay_line.sv
// Module: fixed-depth register delay for one data slice.
// Assumes DEPTH >= 1; a zero-depth path is wired directly by the caller.
// Synchronous active-low reset clears every stage.
module nco_delay_line #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [DEPTH];

    // Shift the slice one stage further per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/nco_segment.sv
// Module: one adder segment of the phase accumulator.
// Adds its increment slice and the registered carry from the segment
// below, and registers both its partial sum and its own carry out.
// Assumes cin and inc_slice already refer to the same accumulation step.
module nco_segment #(
    parameter int SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] inc_slice,
    input  logic             cin,
    output logic [SEG_W-1:0] sum_q,
    output logic             cout_q
);

    logic [SEG_W:0] total;

    // Narrow add: only SEG_W bits of carry chain per clock.
    always_comb total = {1'b0, sum_q} + {1'b0, inc_slice} + {{SEG_W{1'b0}}, cin};

    // Register the partial sum and the carry handed to the next segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            cout_q <= 1'b0;
        end else begin
            sum_q  <= total[SEG_W-1:0];
            cout_q <= total[SEG_W];
        end
    end

endmodule

// File: rtl/nco_fill_tracker.sv
// Module: counts edges after reset release and flags when the aligned
// phase output first contains a post-reset increment.
// Assumes FILL equals input register plus segment count.
module nco_fill_tracker #(
    parameter int FILL = 5,
    localparam int CNT_W = $clog2(FILL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic valid
);

    logic [CNT_W-1:0] cnt_q;

    // Saturating count of edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (cnt_q != CNT_W'(FILL))      cnt_q <= cnt_q + 1'b1;
    end

    assign valid = (cnt_q == CNT_W'(FILL));

endmodule

// File: rtl/nco_phase_acc.sv
// Module: carry-segmented pipelined phase accumulator (top).
// Registers the increment, skews its slices by segment index, runs one
// narrow adder per segment with registered carries between them, and
// deskews the partial sums into an aligned phase word.
// Assumes PHASE_W is a multiple of SEG_W. Synchronous active-low reset.
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int SEG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] inc_in,
    output logic [PHASE_W-1:0] phase_out,
    output logic               square_out,
    output logic               phase_valid
);

    localparam int NSEG = seg_count(PHASE_W, SEG_W);
    localparam int FILL = fill_edges(PHASE_W, SEG_W);

    logic [PHASE_W-1:0] inc_q;
    logic [SEG_W-1:0]   inc_al  [NSEG];
    logic [SEG_W-1:0]   seg_sum [NSEG];
    logic [NSEG-1:0]    carry_q;
    logic [PHASE_W-1:0] phase_al;

    // Capture the increment word once at the block edge.
    always_ff @(posedge clk) begin
        if (!rst_n) inc_q <= '0;
        else        inc_q <= inc_in;
    end

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        // Skew: segment k sees its increment slice k clocks late.
        if (k == 0) begin : g_skew0
            assign inc_al[k] = inc_q[k*SEG_W +: SEG_W];
        end else begin : g_skew
            nco_delay_line #(.WIDTH(SEG_W), .DEPTH(k)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (inc_q[k*SEG_W +: SEG_W]),
                .q     (inc_al[k])
            );
        end

        // Adder segment; the lowest takes no carry in.
        if (k == 0) begin : g_add0
            nco_segment #(.SEG_W(SEG_W)) u_add (
                .clk       (clk),
                .rst_n     (rst_n),
                .inc_slice (inc_al[k]),
                .cin       (1'b0),
                .sum_q     (seg_sum[k]),
                .cout_q    (carry_q[k])
            );
        end else begin : g_add
            nco_segment #(.SEG_W(SEG_W)) u_add (
                .clk       (clk),
                .rst_n     (rst_n),
                .inc_slice (inc_al[k]),
                .cin       (carry_q[k-1]),
                .sum_q     (seg_sum[k]),
                .cout_q    (carry_q[k])
            );
        end

        // Deskew: lower segments wait for the top one to finish the step.
        if (k == NSEG - 1) begin : g_desk_top
            assign phase_al[k*SEG_W +: SEG_W] = seg_sum[k];
        end else begin : g_desk
            nco_delay_line #(.WIDTH(SEG_W), .DEPTH(NSEG - 1 - k)) u_desk (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (seg_sum[k]),
                .q     (phase_al[k*SEG_W +: SEG_W])
            );
        end
    end

    nco_fill_tracker #(.FILL(FILL)) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (phase_valid)
    );

    assign phase_out  = phase_al;
    assign square_out = phase_al[PHASE_W-1];

endmodule

// File: rtl/nco_phase_acc_chk.sv
// Module: assertion checker bound to nco_phase_acc.
// Watches the aligned phase, the valid flag and the top segment carry.
module nco_phase_acc_chk #(
    parameter int PHASE_W = 32,
    parameter int FILL    = 5,
    localparam int CW     = $clog2(FILL + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PHASE_W-1:0] phase_out,
    input logic               phase_valid,
    input logic               top_carry
);

    logic [CW-1:0] edges_q;

    // Independent count of edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)                    edges_q <= '0;
        else if (edges_q != CW'(FILL)) edges_q <= edges_q + 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (phase_out == '0 && !phase_valid)); // R1

    AST_RAMP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        !top_carry |-> (phase_out >= $past(phase_out))); // R2

    AST_WRAP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        top_carry |-> (phase_out < $past(phase_out))); // R6

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |=> phase_valid); // R5

    AST_VALID_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid == (edges_q == CW'(FILL))); // R5

endmodule

bind nco_phase_acc nco_phase_acc_chk #(.PHASE_W(PHASE_W), .FILL(FILL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_out   (phase_out),
    .phase_valid (phase_valid),
    .top_carry   (carry_q[NSEG-1])
);

// File: tb/tb_nco_phase_acc.sv
// Bench: behavioural running-sum model with a history queue, compared
// against the accumulator on every clock.
module tb_nco_phase_acc;

    localparam int LAT = 4;  // NSEG for 32-bit phase, 8-bit segments

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] inc_in;
    logic [31:0] phase_out;
    logic        square_out;
    logic        phase_valid;

    int n_checks = 0;
    int n_errors = 0;
    string cur_tag = "R1";
    bit model_live = 1'b0;

    logic [31:0] ref_sum;
    logic [31:0] hist[$];
    int          since_rel;

    always #10 clk = ~clk;  // 50 MHz

    nco_phase_acc dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_in      (inc_in),
        .phase_out   (phase_out),
        .square_out  (square_out),
        .phase_valid (phase_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference: running sum, output seen LAT edges later.
    always @(posedge clk) begin
        model_live = 1'b1;
        if (!rst_n) begin
            ref_sum = '0;
            hist.delete();
            for (int i = 0; i <= LAT; i++) hist.push_back('0);
            since_rel = 0;
        end else begin
            ref_sum = ref_sum + inc_in;
            hist.push_back(ref_sum);
            void'(hist.pop_front());
            if (since_rel < 1000000) since_rel++;
        end
    end

    // Compare on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (model_live) begin
            check(phase_out == hist[0], cur_tag, phase_out, hist[0]);
            check(square_out == hist[0][31], "R4", {31'b0, square_out}, {31'b0, hist[0][31]});
            check(phase_valid == (since_rel >= LAT + 1), "R5",
                  {31'b0, phase_valid}, {31'b0, since_rel >= LAT + 1});
        end
    end

    task automatic hold(input logic [31:0] v, input int cycles);
        inc_in = v;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        rst_n  = 1'b0;
        inc_in = 32'h0;
        repeat (4) @(negedge clk);
        // R1: reset with a nonzero increment pending
        inc_in = 32'h1111_1111;
        repeat (2) @(negedge clk);
        check(phase_out == 32'h0 && !phase_valid, "R1", phase_out, 32'h0);

        rst_n = 1'b1;
        cur_tag = "R2";
        hold(32'h0100_0000, 300);
        hold(32'h1234_5679, 200);

        cur_tag = "R6";
        hold(32'h00FF_FFFF, 300);
        hold(32'hFFFF_FFFF, 60);
        hold(32'h0000_0001, 40);

        cur_tag = "R4";
        hold(32'h8000_0000, 20);

        cur_tag = "R3";
        for (int i = 0; i < 400; i++) begin
            inc_in = $urandom;
            @(negedge clk);
        end

        // R1 and R5: mid-run reset, then watch valid refill
        cur_tag = "R1";
        rst_n = 1'b0;
        inc_in = 32'hDEAD_BEEF;
        repeat (2) @(negedge clk);
        check(phase_out == 32'h0, "R1", phase_out, 32'h0);
        rst_n = 1'b1;
        cur_tag = "R5";
        inc_in = 32'h0000_0101;
        repeat (LAT) @(negedge clk);
        check(!phase_valid, "R5", {31'b0, phase_valid}, 32'h0);
        @(negedge clk);
        check(phase_valid && phase_out == 32'h0000_0101, "R5", phase_out, 32'h0000_0101);
        hold(32'h0000_0101, 30);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule